// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Forms

This block is the integer execute stage of a 32-bit load/store core. Each cycle it takes a 32-bit instruction word and the values read for its first and second source registers. One clock edge later it presents a result, the index of the register that result belongs to, and a write enable. It handles arithmetic, logic, compare, shift, rotate and multiply operations. Each of these comes in a form with two register operands or a form with one register operand and a 16-bit immediate. Depending on the opcode, the immediate is sign-extended, zero-extended, or placed in the upper half of the word.

Opcodes outside this scope produce no write. Division, memory access and control transfer are examples. The encodings that the instruction set leaves reserved are also flagged as illegal. Register index 0 always reads as zero and is never written.

Top module: `int_exec_unit`

## Requirements
- R1: Field positions: opcode is bits [5:0], the A index is [31:27] and the B index is [26:22]. Opcode 0x3A selects the register form, where the C index is [21:17], the extended opcode is [16:11] and the immediate shift amount is [10:6]. The other opcodes carry imm16 in [21:6]. `dst_o` shows C for the register form and B for every other opcode. An A index of 0 makes operand A zero. In the register form, a B index of 0 makes operand B zero.
- R2: addi (0x04), muli (0x24, low 32 bits of the product), cmpgei (0x08), cmplti (0x10), cmpnei (0x18) and cmpeqi (0x20) use imm16 sign-extended to 32 bits.
- R3: andi (0x0C), ori (0x14), xori (0x1C), cmpgeui (0x28) and cmpltui (0x30) use imm16 zero-extended to 32 bits.
- R4: andhi (0x2C), orhi (0x34) and xorhi (0x3C) use imm16 shifted left by 16, with zeros in the low half.
- R5: A compare writes 1 when its condition holds and 0 otherwise, comparing operand A with the second operand. The register-form extended opcodes use the same codes as the immediate opcodes: 0x08 is signed >=, 0x10 is signed <, 0x18 is !=, 0x20 is ==, 0x28 is unsigned >= and 0x30 is unsigned <.
- R6: Register-form extended opcodes: add 0x31, sub 0x39 (A-B), mul 0x27 (low 32 bits), and 0x0E, or 0x16, xor 0x1E, nor 0x06.
- R7: The immediate shifts use the amount in bits [10:6]: roli 0x02 (rotate left), slli 0x12, srli 0x1A (logical) and srai 0x3A (arithmetic).
- R8: The register shifts use the amount in operand B bits [4:0]: rol 0x03, ror 0x0B, sll 0x13, srl 0x1B and sra 0x3B.
- R9: mulxuu 0x07, mulxsu 0x17 and mulxss 0x1F return bits [63:32] of the 64-bit product. The operands are taken as unsigned×unsigned, signed A × unsigned B, and signed×signed.
- R10: `wr_en_o` is low whenever the destination index is 0.
- R11: Any other opcode is out of scope: `wr_en_o` low and `illegal_o` low. Out-of-scope opcodes include loads, stores, branches, division, control-register access, cache operations and the no-operation.
- R12: Reserved encodings raise `illegal_o` and leave `wr_en_o` low. The reserved opcodes are 0x02, 0x09, 0x0A, 0x11, 0x12, 0x19, 0x1A, 0x1D, 0x1F, 0x21, 0x22, 0x29, 0x2A, 0x31, 0x39, 0x3D, 0x3E and 0x3F. With opcode 0x3A, the reserved extended opcodes are 0x00, 0x0A, 0x0F, 0x11, 0x15, 0x19, 0x21-0x23, 0x2A-0x2C, 0x2F, 0x32, 0x33, 0x35, 0x37, 0x38 and 0x3C-0x3F.
- R13: The outputs are registered: inputs applied before a rising edge appear after it. While `rst_n` is low, all outputs are zero.
- R14: `result_o` is zero whenever `wr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| rs_a_i | input | XLEN | Value read for the A register |
| rs_b_i | input | XLEN | Value read for the B register |
| result_o | output | XLEN | Computed value, zero when not written |
| dst_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| illegal_o | output | 1 | Reserved encoding seen |

## Verification
The only state in the block is one output register, so a wrong decode cannot hide. It shows at the ports one edge after the offending word as one of four things: a wrong result value, a wrong index, or a write enable or illegal flag that should not be set. Three kinds of error can look correct on most operands: wrong immediate extension, a wrong multiply sign mode, or a misplaced shift amount field. The sweep therefore pairs every opcode with operands that have the top bit set, an immediate of 0xFFFF or 0x8000, and shift amounts of 0 and 31. Register-0 handling is exercised both as a source index and as a destination index.

// File: rtl/iexu_pkg.sv
`timescale 1ns/1ps
package iexu_pkg;
    localparam int unsigned INSN_W  = 32;
    localparam int unsigned IDX_W   = 5;
    localparam int unsigned AMT_W   = 5;
    localparam logic [5:0]  OP_REGF = 6'h3A;

    typedef enum logic [4:0] {
        K_NONE, K_ADD, K_SUB, K_MUL, K_AND, K_OR, K_XOR, K_NOR,
        K_GE, K_LT, K_NE, K_EQ, K_GEU, K_LTU,
        K_ROL, K_ROR, K_SLL, K_SRL, K_SRA,
        K_MHUU, K_MHSU, K_MHSS
    } kind_e;

    typedef enum logic [1:0] {
        SRC_REG, SRC_SEXT, SRC_ZEXT, SRC_HIGH
    } opb_src_e;

    typedef struct packed {
        kind_e             kind;
        opb_src_e          src;
        logic              amt_imm;
        logic [IDX_W-1:0]  dst;
        logic              live;
        logic              rsvd;
    } dec_t;
endpackage

// File: rtl/iexu_decode.sv
`timescale 1ns/1ps
module iexu_decode
    import iexu_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output dec_t              dec
);
    logic [5:0] op;
    logic [5:0] opx;
    logic       regf;

    assign op   = instr[5:0];
    assign opx  = instr[16:11];
    assign regf = (op == OP_REGF);

    always_comb begin
        dec         = '0;
        dec.kind    = K_NONE;
        dec.src     = SRC_REG;
        dec.amt_imm = 1'b0;
        dec.dst     = regf ? instr[21:17] : instr[26:22];
        dec.live    = 1'b1;
        dec.rsvd    = 1'b0;
        if (!regf) begin
            case (op)
                6'h04: begin dec.kind = K_ADD; dec.src = SRC_SEXT; end
                6'h24: begin dec.kind = K_MUL; dec.src = SRC_SEXT; end
                6'h08: begin dec.kind = K_GE;  dec.src = SRC_SEXT; end
                6'h10: begin dec.kind = K_LT;  dec.src = SRC_SEXT; end
                6'h18: begin dec.kind = K_NE;  dec.src = SRC_SEXT; end
                6'h20: begin dec.kind = K_EQ;  dec.src = SRC_SEXT; end
                6'h28: begin dec.kind = K_GEU; dec.src = SRC_ZEXT; end
                6'h30: begin dec.kind = K_LTU; dec.src = SRC_ZEXT; end
                6'h0C: begin dec.kind = K_AND; dec.src = SRC_ZEXT; end
                6'h14: begin dec.kind = K_OR;  dec.src = SRC_ZEXT; end
                6'h1C: begin dec.kind = K_XOR; dec.src = SRC_ZEXT; end
                6'h2C: begin dec.kind = K_AND; dec.src = SRC_HIGH; end
                6'h34: begin dec.kind = K_OR;  dec.src = SRC_HIGH; end
                6'h3C: begin dec.kind = K_XOR; dec.src = SRC_HIGH; end
                6'h02, 6'h09, 6'h0A, 6'h11, 6'h12, 6'h19, 6'h1A, 6'h1D,
                6'h1F, 6'h21, 6'h22, 6'h29, 6'h2A, 6'h31, 6'h39, 6'h3D,
                6'h3E, 6'h3F: begin
                    dec.live = 1'b0;
                    dec.rsvd = 1'b1;
                end
                default: dec.live = 1'b0;
            endcase
        end else begin
            case (opx)
                6'h31: dec.kind = K_ADD;
                6'h39: dec.kind = K_SUB;
                6'h27: dec.kind = K_MUL;
                6'h0E: dec.kind = K_AND;
                6'h16: dec.kind = K_OR;
                6'h1E: dec.kind = K_XOR;
                6'h06: dec.kind = K_NOR;
                6'h08: dec.kind = K_GE;
                6'h10: dec.kind = K_LT;
                6'h18: dec.kind = K_NE;
                6'h20: dec.kind = K_EQ;
                6'h28: dec.kind = K_GEU;
                6'h30: dec.kind = K_LTU;
                6'h02: begin dec.kind = K_ROL; dec.amt_imm = 1'b1; end
                6'h12: begin dec.kind = K_SLL; dec.amt_imm = 1'b1; end
                6'h1A: begin dec.kind = K_SRL; dec.amt_imm = 1'b1; end
                6'h3A: begin dec.kind = K_SRA; dec.amt_imm = 1'b1; end
                6'h03: dec.kind = K_ROL;
                6'h0B: dec.kind = K_ROR;
                6'h13: dec.kind = K_SLL;
                6'h1B: dec.kind = K_SRL;
                6'h3B: dec.kind = K_SRA;
                6'h07: dec.kind = K_MHUU;
                6'h17: dec.kind = K_MHSU;
                6'h1F: dec.kind = K_MHSS;
                6'h00, 6'h0A, 6'h0F, 6'h11, 6'h15, 6'h19, 6'h21, 6'h22,
                6'h23, 6'h2A, 6'h2B, 6'h2C, 6'h2F, 6'h32, 6'h33, 6'h35,
                6'h37, 6'h38, 6'h3C, 6'h3D, 6'h3E, 6'h3F: begin
                    dec.live = 1'b0;
                    dec.rsvd = 1'b1;
                end
                default: dec.live = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/iexu_shift.sv
`timescale 1ns/1ps
module iexu_shift
    import iexu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0]  a,
    input  logic [AMT_W-1:0] amt,
    input  kind_e            kind,
    output logic [XLEN-1:0]  y
);
    localparam int unsigned DW = 2 * XLEN;

    logic [DW-1:0] dbl;
    logic [DW-1:0] rl;
    logic [DW-1:0] rr;

    always_comb begin
        dbl = {a, a};
        rl  = dbl << amt;
        rr  = dbl >> amt;
        case (kind)
            K_ROL:   y = rl[DW-1:XLEN];
            K_ROR:   y = rr[XLEN-1:0];
            K_SLL:   y = a << amt;
            K_SRL:   y = a >> amt;
            K_SRA:   y = $signed(a) >>> amt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/iexu_mul.sv
`timescale 1ns/1ps
module iexu_mul
    import iexu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  kind_e           kind,
    output logic [XLEN-1:0] lo,
    output logic [XLEN-1:0] hi
);
    localparam int unsigned PW = 2 * XLEN;

    logic          sgn_a;
    logic          sgn_b;
    logic [PW-1:0] ea;
    logic [PW-1:0] eb;
    logic [PW-1:0] prod;

    always_comb begin
        sgn_a = (kind == K_MHSU) || (kind == K_MHSS);
        sgn_b = (kind == K_MHSS);
        ea    = {{XLEN{sgn_a & a[XLEN-1]}}, a};
        eb    = {{XLEN{sgn_b & b[XLEN-1]}}, b};
        prod  = ea * eb;
        lo    = prod[XLEN-1:0];
        hi    = prod[PW-1:XLEN];
    end
endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  rs_a_i,
    input  logic [XLEN-1:0]  rs_b_i,
    output logic [XLEN-1:0]  result_o,
    output logic [4:0]       dst_o,
    output logic             wr_en_o,
    output logic             illegal_o
);
    typedef struct packed {
        logic [XLEN-1:0]  res;
        logic [IDX_W-1:0] dst;
        logic             we;
        logic             ill;
    } out_t;

    dec_t             dec;
    logic [XLEN-1:0]  opa;
    logic [XLEN-1:0]  opb_reg;
    logic [XLEN-1:0]  opb;
    logic [15:0]      imm16;
    logic [AMT_W-1:0] amt;
    logic [XLEN-1:0]  sh_y;
    logic [XLEN-1:0]  mul_lo;
    logic [XLEN-1:0]  mul_hi;
    logic [XLEN-1:0]  val;
    logic             lt_s;
    logic             lt_u;
    logic             eq;
    out_t             out_d;
    out_t             out_q;

    iexu_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    always_comb begin
        opa     = (instr_i[31:27] == '0) ? '0 : rs_a_i;
        opb_reg = (instr_i[26:22] == '0) ? '0 : rs_b_i;
        imm16   = instr_i[21:6];
        case (dec.src)
            SRC_SEXT: opb = XLEN'($signed(imm16));
            SRC_ZEXT: opb = XLEN'(imm16);
            SRC_HIGH: opb = XLEN'({imm16, 16'h0000});
            default:  opb = opb_reg;
        endcase
        amt = dec.amt_imm ? instr_i[10:6] : opb_reg[AMT_W-1:0];
    end

    iexu_shift #(.XLEN(XLEN)) u_shift (
        .a    (opa),
        .amt  (amt),
        .kind (dec.kind),
        .y    (sh_y)
    );

    iexu_mul #(.XLEN(XLEN)) u_mul (
        .a    (opa),
        .b    (opb),
        .kind (dec.kind),
        .lo   (mul_lo),
        .hi   (mul_hi)
    );

    always_comb begin
        lt_s = $signed(opa) < $signed(opb);
        lt_u = opa < opb;
        eq   = (opa == opb);
        case (dec.kind)
            K_ADD:  val = opa + opb;
            K_SUB:  val = opa - opb;
            K_MUL:  val = mul_lo;
            K_AND:  val = opa & opb;
            K_OR:   val = opa | opb;
            K_XOR:  val = opa ^ opb;
            K_NOR:  val = ~(opa | opb);
            K_GE:   val = {{(XLEN-1){1'b0}}, ~lt_s};
            K_LT:   val = {{(XLEN-1){1'b0}}, lt_s};
            K_NE:   val = {{(XLEN-1){1'b0}}, ~eq};
            K_EQ:   val = {{(XLEN-1){1'b0}}, eq};
            K_GEU:  val = {{(XLEN-1){1'b0}}, ~lt_u};
            K_LTU:  val = {{(XLEN-1){1'b0}}, lt_u};
            K_ROL, K_ROR, K_SLL, K_SRL, K_SRA: val = sh_y;
            K_MHUU, K_MHSU, K_MHSS: val = mul_hi;
            default: val = '0;
        endcase
        out_d.dst = dec.dst;
        out_d.we  = dec.live && (dec.dst != '0);
        out_d.res = out_d.we ? val : '0;
        out_d.ill = dec.rsvd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o  = out_q.res;
    assign dst_o     = out_q.dst;
    assign wr_en_o   = out_q.we;
    assign illegal_o = out_q.ill;
endmodule

// File: rtl/iexu_checker.sv
`timescale 1ns/1ps
module iexu_checker #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] rs_a_i,
    input logic [XLEN-1:0] rs_b_i,
    input logic [XLEN-1:0] result_o,
    input logic [4:0]      dst_o,
    input logic            wr_en_o,
    input logic            illegal_o
);
    logic       armed_q;
    logic       is_cmp;
    logic [5:0] code;
    logic       unused_ok;

    assign unused_ok = ^{rs_a_i, rs_b_i};
    assign code      = (instr_i[5:0] == 6'h3A) ? instr_i[16:11] : instr_i[5:0];
    assign is_cmp    = (code[2:0] == 3'b000) && (code[5:3] != 3'd0) && (code[5:3] != 3'd7);

    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_WE_DST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (dst_o != 5'd0));                                        // R10
    AST_RES_ZERO_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> (result_o == '0));                                      // R14
    AST_ILLEGAL_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wr_en_o);                                             // R12
    AST_CMP_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(is_cmp) && wr_en_o) |-> (result_o[XLEN-1:1] == '0)); // R5
    AST_DST_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (dst_o == (($past(instr_i[5:0]) == 6'h3A) ?
                     $past(instr_i[21:17]) : $past(instr_i[26:22]))));       // R1
endmodule

bind int_exec_unit iexu_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;
    typedef struct {
        logic [31:0] res;
        logic        we;
        logic [4:0]  dst;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] ra = '0;
    logic [31:0] rb = '0;
    logic [31:0] result;
    logic [4:0]  dst;
    logic        we;
    logic        ill;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .rs_a_i(ra), .rs_b_i(rb),
        .result_o(result), .dst_o(dst), .wr_en_o(we), .illegal_o(ill)
    );

    function automatic logic [31:0] rotl(logic [31:0] x, logic [4:0] n);
        return (n == 0) ? x : ((x << n) | (x >> (6'd32 - n)));
    endfunction

    function automatic logic [31:0] b2w(bit c);
        return c ? 32'd1 : 32'd0;
    endfunction

    function automatic exp_t model(logic [31:0] ins, logic [31:0] xa, logic [31:0] xb);
        exp_t e;
        logic [31:0] a, b, si, zi, hi, v;
        logic [63:0] full;
        logic live, isr;
        logic [4:0] ni, nr;
        a  = (ins[31:27] == 0) ? 32'd0 : xa;
        b  = (ins[26:22] == 0) ? 32'd0 : xb;
        si = {{16{ins[21]}}, ins[21:6]};
        zi = {16'h0, ins[21:6]};
        hi = {ins[21:6], 16'h0};
        ni = ins[10:6];
        nr = b[4:0];
        isr = (ins[5:0] == 6'h3A);
        live = 1'b1;
        e.ill = 1'b0;
        v = 0;
        e.dst = isr ? ins[21:17] : ins[26:22];
        if (!isr) begin
            case (ins[5:0])
                6'h04: begin v = a + si; e.tag = "R2"; end
                6'h24: begin v = a * si; e.tag = "R2"; end
                6'h08: begin v = b2w($signed(a) >= $signed(si)); e.tag = "R2,R5"; end
                6'h10: begin v = b2w($signed(a) <  $signed(si)); e.tag = "R2,R5"; end
                6'h18: begin v = b2w(a != si); e.tag = "R2,R5"; end
                6'h20: begin v = b2w(a == si); e.tag = "R2,R5"; end
                6'h28: begin v = b2w(a >= zi); e.tag = "R3,R5"; end
                6'h30: begin v = b2w(a <  zi); e.tag = "R3,R5"; end
                6'h0C: begin v = a & zi; e.tag = "R3"; end
                6'h14: begin v = a | zi; e.tag = "R3"; end
                6'h1C: begin v = a ^ zi; e.tag = "R3"; end
                6'h2C: begin v = a & hi; e.tag = "R4"; end
                6'h34: begin v = a | hi; e.tag = "R4"; end
                6'h3C: begin v = a ^ hi; e.tag = "R4"; end
                6'h02, 6'h09, 6'h0A, 6'h11, 6'h12, 6'h19, 6'h1A, 6'h1D, 6'h1F,
                6'h21, 6'h22, 6'h29, 6'h2A, 6'h31, 6'h39, 6'h3D, 6'h3E, 6'h3F:
                    begin live = 0; e.ill = 1; e.tag = "R12"; end
                default: begin live = 0; e.tag = "R11"; end
            endcase
        end else begin
            case (ins[16:11])
                6'h31: begin v = a + b; e.tag = "R6"; end
                6'h39: begin v = a - b; e.tag = "R6"; end
                6'h27: begin v = a * b; e.tag = "R6"; end
                6'h0E: begin v = a & b; e.tag = "R6"; end
                6'h16: begin v = a | b; e.tag = "R6"; end
                6'h1E: begin v = a ^ b; e.tag = "R6"; end
                6'h06: begin v = ~(a | b); e.tag = "R6"; end
                6'h08: begin v = b2w($signed(a) >= $signed(b)); e.tag = "R5"; end
                6'h10: begin v = b2w($signed(a) <  $signed(b)); e.tag = "R5"; end
                6'h18: begin v = b2w(a != b); e.tag = "R5"; end
                6'h20: begin v = b2w(a == b); e.tag = "R5"; end
                6'h28: begin v = b2w(a >= b); e.tag = "R5"; end
                6'h30: begin v = b2w(a <  b); e.tag = "R5"; end
                6'h02: begin v = rotl(a, ni); e.tag = "R7"; end
                6'h12: begin v = a << ni; e.tag = "R7"; end
                6'h1A: begin v = a >> ni; e.tag = "R7"; end
                6'h3A: begin v = $signed(a) >>> ni; e.tag = "R7"; end
                6'h03: begin v = rotl(a, nr); e.tag = "R8"; end
                6'h0B: begin v = rotl(a, 5'(6'd32 - {1'b0, nr})); e.tag = "R8"; end
                6'h13: begin v = a << nr; e.tag = "R8"; end
                6'h1B: begin v = a >> nr; e.tag = "R8"; end
                6'h3B: begin v = $signed(a) >>> nr; e.tag = "R8"; end
                6'h07: begin full = {32'd0, a} * {32'd0, b}; v = full[63:32]; e.tag = "R9"; end
                6'h17: begin full = {{32{a[31]}}, a} * {32'd0, b}; v = full[63:32]; e.tag = "R9"; end
                6'h1F: begin full = {{32{a[31]}}, a} * {{32{b[31]}}, b}; v = full[63:32]; e.tag = "R9"; end
                6'h00, 6'h0A, 6'h0F, 6'h11, 6'h15, 6'h19, 6'h21, 6'h22, 6'h23, 6'h2A, 6'h2B,
                6'h2C, 6'h2F, 6'h32, 6'h33, 6'h35, 6'h37, 6'h38, 6'h3C, 6'h3D, 6'h3E, 6'h3F:
                    begin live = 0; e.ill = 1; e.tag = "R12"; end
                default: begin live = 0; e.tag = "R11"; end
            endcase
        end
        e.we = live && (e.dst != 0);
        e.res = e.we ? v : 32'd0;
        if (!e.we) e.tag = {e.tag, ",R14"};
        if (live && e.dst == 0) e.tag = {e.tag, ",R10"};
        if (ins[31:27] == 0 || (isr && ins[26:22] == 0)) e.tag = {e.tag, ",R1"};
        return e;
    endfunction

    function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] ia, logic [4:0] ib, logic [15:0] imm);
        return {ia, ib, imm, op};
    endfunction

    function automatic logic [31:0] mk_r(logic [5:0] opx, logic [4:0] ia, logic [4:0] ib, logic [4:0] ic, logic [4:0] sh);
        return {ia, ib, ic, opx, sh, 6'h3A};
    endfunction

    task automatic drive(logic [31:0] ins, logic [31:0] xa, logic [31:0] xb);
        @(negedge clk);
        instr = ins;
        ra = xa;
        rb = xb;
        q.push_back(model(ins, xa, xb));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: outputs change at posedge; compare 2 ns later
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (result !== e.res || we !== e.we || dst !== e.dst || ill !== e.ill) begin
                    n_fail++;
                    $display("FAIL %s R13: actual res=%h we=%b dst=%0d ill=%b expected res=%h we=%b dst=%0d ill=%b",
                             e.tag, result, we, dst, ill, e.res, e.we, e.dst, e.ill);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R13 watchdog: actual hung, expected completion");
            summary();
            $finish;
        end
    end

    logic [31:0] ca [4] = '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF};

    initial begin
        // reset with live stimulus on the inputs (R13)
        instr = mk_r(6'h31, 5'd1, 5'd2, 5'd3, 5'd0);
        ra = 32'h1234_5678;
        rb = 32'h1111_1111;
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (result !== 0 || we !== 0 || dst !== 0 || ill !== 0) begin
            n_fail++;
            $display("FAIL R13 reset: actual res=%h we=%b dst=%0d ill=%b expected all zero",
                     result, we, dst, ill);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        drive(mk_i(6'h04, 5'd1, 5'd2, 16'hFFFF), 32'h8000_0000, 32'h0);      // R2 addi -1
        drive(mk_i(6'h10, 5'd1, 5'd2, 16'h8000), 32'h8000_0000, 32'h0);      // R2 cmplti
        drive(mk_i(6'h30, 5'd1, 5'd2, 16'h8000), 32'h0000_7FFF, 32'h0);      // R3 cmpltui
        drive(mk_i(6'h34, 5'd1, 5'd2, 16'hA5A5), 32'h0000_00FF, 32'h0);      // R4 orhi
        drive(mk_r(6'h3A, 5'd1, 5'd0, 5'd4, 5'd31), 32'h8000_0000, 32'h0);   // R7 srai 31
        drive(mk_r(6'h0B, 5'd1, 5'd2, 5'd4, 5'd0), 32'h8000_0001, 32'd33);   // R8 ror by 1 from rB[4:0]
        drive(mk_r(6'h1F, 5'd1, 5'd2, 5'd4, 5'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9 mulxss
        drive(mk_r(6'h17, 5'd1, 5'd2, 5'd4, 5'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9 mulxsu
        drive(mk_r(6'h07, 5'd1, 5'd2, 5'd4, 5'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R9 mulxuu
        drive(mk_r(6'h31, 5'd0, 5'd0, 5'd4, 5'd0), 32'hDEAD_BEEF, 32'h1);    // R1 r0 sources
        drive(mk_r(6'h31, 5'd1, 5'd2, 5'd0, 5'd0), 32'h5, 32'h6);            // R10 dst r0
        drive(mk_i(6'h02, 5'd1, 5'd2, 16'h1234), 32'h5, 32'h6);              // R12 reserved
        drive(mk_i(6'h17, 5'd1, 5'd2, 16'h1234), 32'h5, 32'h6);              // R11 load

        // sweep every opcode and extended opcode
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 6; k++) begin
                logic [4:0]  ia, ib;
                logic [15:0] imm;
                logic [31:0] xa;
                ia  = 5'($urandom_range(1, 31));
                ib  = 5'($urandom_range(1, 31));
                imm = 16'($urandom);
                xa  = $urandom;
                case (k)
                    1: begin xa = ca[0]; imm = 16'hFFFF; end
                    2: begin xa = ca[1]; imm = 16'h8000; end
                    3: begin xa = ca[3]; imm = 16'h7FFF; end
                    4: ia = 5'd0;
                    5: ib = 5'd0;
                    default: ;
                endcase
                drive(mk_i(6'(op), ia, ib, imm), xa, $urandom);
            end
        end
        for (int opx = 0; opx < 64; opx++) begin
            for (int k = 0; k < 7; k++) begin
                logic [4:0]  ia, ib, ic, sh;
                logic [31:0] xa, xb;
                ia = 5'($urandom_range(1, 31));
                ib = 5'($urandom_range(1, 31));
                ic = 5'($urandom_range(1, 31));
                sh = 5'($urandom);
                xa = $urandom;
                xb = $urandom;
                case (k)
                    1: begin xa = ca[0]; xb = ca[1]; sh = 5'd31; end
                    2: begin xa = ca[1]; xb = 32'd31; sh = 5'd0; end
                    3: begin xa = ca[3]; xb = ca[0]; end
                    4: begin ia = 5'd0; end
                    5: begin ib = 5'd0; end
                    6: begin ic = 5'd0; end
                    default: ;
                endcase
                drive(mk_r(6'(opx), ia, ib, ic, sh), xa, xb);
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule